// File: doc/BRIEF.md
# Node Signature Match Search Engine

This block looks through a stored table of node behaviours for a source of a required rectification sequence. Each node's behaviour is one bit vector. Bit `s` of the vector is the node's logic value when the system's source signals hold the binary value `s`, so the states run upward from all-zeros to all-ones. A search is started with a target sequence, a compare mask and an exclusion mask. The engine then tries candidates one per clock: each node unchanged, each node inverted, and every pair of nodes combined through AND and through OR. It stops at the first candidate that agrees with the target on every compared state.

The compare mask lets a caller that knows the target repeats compare only one period, for example the lower 16 of 32 states. The exclusion mask removes the nodes that lie downstream of the faulty unit. The engine reports whether it found a match, which of the four candidate kinds it was, and the node indices involved. When it reports no match, the repair has to be built from the faulty unit's own inputs.

Top module: `node_sig_search`

## Requirements
- R1: After reset, `busy`, `done`, `hit`, `kind`, `node_a` and `node_b` are all 0.
- R2: Candidates are tried in a fixed order. First come all single nodes in rising index order, then all inverted nodes in rising index order. Then come the pairs (a,b) with a<b, ordered by a and then by b, and each pair is tried as AND before OR. The first match in this order is reported. `kind` is 0 for a direct match, 1 for an inverted match, 2 for AND and 3 for OR. For kinds 0 and 1, `node_b` equals `node_a`.
- R3: A node whose vector equals the target on all compared states is reported with kind 0.
- R4: A node whose complement equals the target on all compared states is reported with kind 1.
- R5: A pair whose bitwise AND or OR equals the target is reported with kind 2 or 3, and with `node_a` < `node_b`.
- R6: Only the states whose bit is 1 in `cmp_mask` are compared. The other target bits have no effect on the result.
- R7: A node whose bit is set in `excl` is never reported, either alone or as part of a pair.
- R8: If no candidate matches, the engine ends with `done`=1, `hit`=0, `kind`=0 and `node_a`=`node_b`=0, after trying all 2N+N(N-1) candidates.
- R9: A start sampled while idle sets `busy` at the next edge. Candidate k (counting from 0) is tried k cycles later, so on a hit `done` rises k+1 edges after the start edge. `busy` and `done` are never high together.
- R10: The target, mask and exclusion are captured when the start is sampled. A start received while busy is ignored. The results hold unchanged until the next accepted start, and that start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a search |
| node_tbl | input | N_NODES*N_STATES | Node vectors; node i sits at bits [i*N_STATES +: N_STATES] |
| target | input | N_STATES | Required sequence, bit s = state s |
| cmp_mask | input | N_STATES | 1 marks a state that is compared |
| excl | input | N_NODES | 1 removes a node from the candidates |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid |
| hit | output | 1 | A match was found |
| kind | output | 2 | 0 direct, 1 inverted, 2 AND, 3 OR |
| node_a | output | $clog2(N_NODES) | First node of the match |
| node_b | output | $clog2(N_NODES) | Second node (equals node_a for kinds 0 and 1) |

## Verification
The hardest case to reach is a target that several candidates satisfy at once, because only the ordering decides which one is reported. The bench builds its table by hand so that such ties exist on purpose: a node and the complement of an earlier node match together, and an excluded node shares its vector with a later node. A behavioural reference then walks the candidate list in the required order. The no-match case is forced by excluding every node, which runs the search through its full length and exercises the pair-advance logic up to the last pair.

// File: rtl/node_sig_search.sv
module node_sig_search #(
  parameter int N_NODES  = 8,
  parameter int N_STATES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [N_NODES*N_STATES-1:0]   node_tbl,
  input  logic [N_STATES-1:0]           target,
  input  logic [N_STATES-1:0]           cmp_mask,
  input  logic [N_NODES-1:0]            excl,
  output logic                          busy,
  output logic                          done,
  output logic                          hit,
  output logic [1:0]                    kind,
  output logic [$clog2(N_NODES)-1:0]    node_a,
  output logic [$clog2(N_NODES)-1:0]    node_b
);
  localparam int IW = $clog2(N_NODES);
  localparam logic [IW-1:0] LASTI = IW'(N_NODES - 1);

  logic [1:0]          ph_q;
  logic [IW-1:0]       ca_q, cb_q;
  logic [N_STATES-1:0] tgt_q, msk_q, cand, va, vb;
  logic [N_NODES-1:0]  exq_q;
  logic                allowed, ok, last_single, final_cand;

  assign va = node_tbl[int'(ca_q)*N_STATES +: N_STATES];
  assign vb = node_tbl[int'(cb_q)*N_STATES +: N_STATES];

  always_comb begin
    case (ph_q)
      2'd0:    cand = va;
      2'd1:    cand = ~va;
      2'd2:    cand = va & vb;
      default: cand = va | vb;
    endcase
  end

  assign allowed     = !exq_q[ca_q] && (!ph_q[1] || !exq_q[cb_q]);
  assign ok          = allowed && (((cand ^ tgt_q) & msk_q) == '0);
  assign last_single = (ca_q == LASTI);
  assign final_cand  = (ph_q == 2'd3) && (ca_q == LASTI - IW'(1)) && (cb_q == LASTI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; hit <= 1'b0; kind <= '0;
      node_a <= '0; node_b <= '0;
      ph_q <= '0; ca_q <= '0; cb_q <= '0;
      tgt_q <= '0; msk_q <= '0; exq_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; done <= 1'b0; hit <= 1'b0; kind <= '0;
        node_a <= '0; node_b <= '0;
        ph_q <= '0; ca_q <= '0; cb_q <= '0;
        tgt_q <= target; msk_q <= cmp_mask; exq_q <= excl;
      end
    end else if (ok) begin
      busy <= 1'b0; done <= 1'b1; hit <= 1'b1; kind <= ph_q;
      node_a <= ca_q;
      node_b <= ph_q[1] ? cb_q : ca_q;
    end else if (final_cand) begin
      busy <= 1'b0; done <= 1'b1;
    end else begin
      case (ph_q)
        2'd0: if (last_single) begin ph_q <= 2'd1; ca_q <= '0; end
              else ca_q <= ca_q + IW'(1);
        2'd1: if (last_single) begin ph_q <= 2'd2; ca_q <= '0; cb_q <= IW'(1); end
              else ca_q <= ca_q + IW'(1);
        2'd2: ph_q <= 2'd3;
        default: begin
          ph_q <= 2'd2;
          if (cb_q == LASTI) begin
            ca_q <= ca_q + IW'(1);
            cb_q <= ca_q + IW'(2);
          end else cb_q <= cb_q + IW'(1);
        end
      endcase
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R9
  AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) hit |-> done); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable({hit, kind, node_a, node_b})); // R10
  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit && kind[1] |-> node_a < node_b); // R5
  AST_SINGLE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit && !kind[1] |-> node_a == node_b); // R2
  AST_NO_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> !exq_q[node_a] && !exq_q[node_b]); // R7
endmodule

// File: tb/tb_node_sig_search.sv
module tb_node_sig_search;
  localparam int N = 8;
  localparam int S = 32;

  logic clk = 0, rst_n = 0, start = 0;
  logic [S-1:0] tbl [N];
  logic [N*S-1:0] flat;
  logic [S-1:0] target = '0, cmp_mask = '1;
  logic [N-1:0] excl = '0;
  logic busy, done, hit;
  logic [1:0] kind;
  logic [2:0] node_a, node_b;

  int checks = 0, failures = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) flat[i*S +: S] = tbl[i];

  node_sig_search #(.N_NODES(N), .N_STATES(S)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .node_tbl(flat), .target(target),
    .cmp_mask(cmp_mask), .excl(excl), .busy(busy), .done(done), .hit(hit),
    .kind(kind), .node_a(node_a), .node_b(node_b));

  // behavioural reference
  logic rbusy = 0, rdone = 0, rhit = 0;
  logic [1:0] rkind = 0;
  logic [2:0] ra = 0, rb = 0;
  int rcnt = 0, elat = 0;
  logic ehit = 0;
  logic [1:0] ekind = 0;
  logic [2:0] ea = 0, eb = 0;

  function automatic bit agree(logic [S-1:0] v, logic [S-1:0] t, logic [S-1:0] m);
    return ((v ^ t) & m) == '0;
  endfunction

  task automatic ref_search(input logic [S-1:0] t, input logic [S-1:0] m, input logic [N-1:0] ex);
    int k = 0;
    ehit = 0; ekind = 0; ea = 0; eb = 0;
    for (int i = 0; i < N; i++) begin
      if (!ehit && !ex[i] && agree(tbl[i], t, m)) begin ehit = 1; ekind = 0; ea = 3'(i); eb = 3'(i); elat = k; end
      k++;
    end
    for (int i = 0; i < N; i++) begin
      if (!ehit && !ex[i] && agree(~tbl[i], t, m)) begin ehit = 1; ekind = 1; ea = 3'(i); eb = 3'(i); elat = k; end
      k++;
    end
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        if (!ehit && !ex[i] && !ex[j] && agree(tbl[i] & tbl[j], t, m)) begin ehit = 1; ekind = 2; ea = 3'(i); eb = 3'(j); elat = k; end
        k++;
        if (!ehit && !ex[i] && !ex[j] && agree(tbl[i] | tbl[j], t, m)) begin ehit = 1; ekind = 3; ea = 3'(i); eb = 3'(j); elat = k; end
        k++;
      end
    if (!ehit) elat = k - 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbusy = 0; rdone = 0; rhit = 0; rkind = 0; ra = 0; rb = 0; rcnt = 0;
    end else if (!rbusy) begin
      if (start) begin
        ref_search(target, cmp_mask, excl);
        rbusy = 1; rdone = 0; rhit = 0; rkind = 0; ra = 0; rb = 0; rcnt = 0;
      end
    end else if (rcnt == elat) begin
      rbusy = 0; rdone = 1; rhit = ehit; rkind = ekind; ra = ea; rb = eb;
    end else rcnt++;
  end

  task automatic chk(input bit cond, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [10:0] a, e;
    a = {busy, done, hit, kind, node_a, node_b};
    e = {rbusy, rdone, rhit, rkind, ra, rb};
    chk(a == e, tag, "cycle compare {busy,done,hit,kind,a,b}", longint'(a), longint'(e));
  end

  task automatic run(input logic [S-1:0] t, input logic [S-1:0] m, input logic [N-1:0] ex, input string req);
    tag = req;
    @(negedge clk);
    target = t; cmp_mask = m; excl = ex; start = 1;
    @(negedge clk);
    start = 0;
    for (int w = 0; w < 200 && !done; w++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_res(input bit h, input logic [1:0] k, input logic [2:0] a, input logic [2:0] b, input string req);
    chk(done == 1'b1, req, "done", longint'(done), 1);
    chk({hit, kind, node_a, node_b} == {h, k, a, b}, req, "{hit,kind,a,b}",
        longint'({hit, kind, node_a, node_b}), longint'({h, k, a, b}));
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // hand-built table with deliberate ties
    tbl[0] = 32'h0F0F_0F0F;
    tbl[1] = 32'hF0F0_F0F0;   // complement of node 0
    tbl[2] = 32'hFF00_FF00;
    tbl[3] = 32'hCCCC_CCCC;
    tbl[4] = 32'h1234_5678;
    tbl[5] = 32'hAAAA_5555;
    tbl[6] = 32'hAAAA_5555;   // same as node 5
    tbl[7] = 32'h8000_0001;
    repeat (3) @(negedge clk);
    chk({busy, done, hit, kind, node_a, node_b} == '0, "R1", "reset outputs",
        longint'({busy, done, hit, kind, node_a, node_b}), 0);
    rst_n = 1;

    run(32'hF0F0_F0F0, '1, '0, "R2");         // direct node1 precedes invert node0
    expect_res(1, 0, 1, 1, "R2");
    run(32'h1234_5678, '1, '0, "R3");
    expect_res(1, 0, 4, 4, "R3");
    run(~32'hCCCC_CCCC, '1, '0, "R4");
    expect_res(1, 1, 3, 3, "R4");
    run(32'hFF00_FF00 & 32'hCCCC_CCCC, '1, '0, "R5");
    expect_res(1, 2, 2, 3, "R5");
    run(32'h1234_5678 | 32'h8000_0001, '1, '0, "R5");
    expect_res(1, 3, 4, 7, "R5");
    run(32'hAAAA_5555, '1, 8'h20, "R7");       // node 5 excluded, node 6 found
    expect_res(1, 0, 6, 6, "R7");
    run({16'hDEAD, 16'h5678}, 32'h0000_FFFF, '0, "R6");
    expect_res(1, 0, 4, 4, "R6");
    run(32'h1234_5678, '1, 8'hFF, "R8");       // every node excluded
    expect_res(0, 0, 0, 0, "R8");

    // R9: hit on candidate 0 -> done one edge after busy
    tag = "R9";
    @(negedge clk); target = 32'h0F0F_0F0F; cmp_mask = '1; excl = '0; start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done, "R9", "busy after start", longint'({busy, done}), 2);
    @(negedge clk);
    expect_res(1, 0, 0, 0, "R9");

    // R10: start while busy ignored, inputs changed mid-search
    tag = "R10";
    @(negedge clk); target = 32'h1234_5678; cmp_mask = '1; excl = 8'hFF; start = 1;
    @(negedge clk); target = 32'h0F0F_0F0F; excl = '0;
    @(negedge clk); start = 0;
    for (int w = 0; w < 200 && !done; w++) @(negedge clk);
    expect_res(0, 0, 0, 0, "R10");
    repeat (4) @(negedge clk);
    expect_res(0, 0, 0, 0, "R10");

    // random tables and pair targets
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < N; i++) tbl[i] = $urandom;
      run(tbl[n % N] & tbl[(n + 3) % N], '1, 8'(1 << (n % 3)), "R2");
      run($urandom, 32'h0000_FFFF, '0, "R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule